// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block turns an asynchronous serial line into characters. A free-running enable that pulses sixteen times per bit period sets the timing. The line is synchronised and watched for a high-to-low transition. That transition only proposes a start bit, and the start bit is kept only if the line is still low at the middle of the bit. After that, every data bit, the optional parity bit and the stop bit are sampled at the centre of their bit period.

When a character completes, the block writes it to a downstream FIFO write port. The data byte travels together with three error tags: line break, framing error and parity error. If the FIFO reports full at that moment, the character is discarded and a sticky overrun flag is raised, which stays set until an explicit clear. The data width (5 to 8 bits), parity enable and odd/even parity selection come from static configuration inputs.

Top module: `serial_rx_frontend`

## Requirements
- R1: After reset, `wr_en_o` and `ovr_o` are 0. No character is written while the line stays high.
- R2: A low line seen on a tick while idle is only a candidate start bit. It is accepted only if the line is still low on the 8th tick after that detection tick. Otherwise the receiver returns to idle and writes nothing.
- R3: After an accepted start bit, each following bit is sampled on every 16th tick. Data bits arrive least significant bit first. `cfg_dbits_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `wr_data_o` are 0.
- R4: With `cfg_par_en_i`=1, one parity bit follows the data. `cfg_par_odd_i`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `wr_perr_o`. With parity disabled, `wr_perr_o` is 0.
- R5: A stop bit sampled as 0 sets `wr_ferr_o`. A stop bit sampled as 1 leaves it 0.
- R6: If every sampled bit of a character (data, parity if enabled, and stop) is 0, `wr_brk_o` is set with data 0. The receiver then ignores the line until it is sampled high on a tick, so a long low period produces exactly one character.
- R7: When the stop bit is sampled, `wr_en_o` pulses for exactly one clock cycle. `wr_data_o`, `wr_brk_o`, `wr_ferr_o` and `wr_perr_o` are valid in that same cycle and belong to that character.
- R8: If `fifo_full_i` is 1 when the stop bit is sampled, no write takes place and `ovr_o` becomes 1. It stays 1 across later characters until `ovr_clr_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulsing 16 times per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_dbits_i | input | 2 | Data width select: 0..3 gives 5..8 bits |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| fifo_full_i | input | 1 | Downstream FIFO full |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | Received data, LSB aligned |
| wr_brk_o | output | 1 | Break tag |
| wr_ferr_o | output | 1 | Framing error tag |
| wr_perr_o | output | 1 | Parity error tag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is the break hold-off, which matters only after a whole character of low samples. There the receiver must stay quiet for as long as the line remains low. The stimulus holds the line low for several character times, counts writes over that stretch, and then sends a clean frame to show that the receiver re-arms. The mid-bit rejection boundary comes next: a low pulse exactly eight tick slots long must be dropped. The bench also sends frames with corrupted stop bits, whose trailing low portion looks like a fresh start edge that has to be rejected.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } srx_state_e;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } srx_tags_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;  // idle line is high
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_phase.sv
module srx_phase #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic mid_o,
  output logic full_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == FULL_CNT) ? '0 : cnt_q + 1'b1;
  end

  assign mid_o  = tick_i && (cnt_q == MID_CNT);
  assign full_o = tick_i && (cnt_q == FULL_CNT);
endmodule

// File: rtl/serial_rx_frontend.sv
module serial_rx_frontend #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic [1:0]        cfg_dbits_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              fifo_full_i,
  input  logic              ovr_clr_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_brk_o,
  output logic              wr_ferr_o,
  output logic              wr_perr_o,
  output logic              ovr_o
);
  import srx_pkg::*;

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  srx_state_e         state_q;
  logic               rx_s;
  logic               mid_hit, full_hit, detect, cnt_clr;
  logic [IDX_W-1:0]   idx_q, last_idx;
  logic [DATA_W-1:0]  sr_q;
  logic               par_q, seen_one_q;
  srx_tags_t          tags_d, tags_q;
  logic [DATA_W-1:0]  data_q;
  logic               wr_q, ovr_q;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  srx_phase #(.OSR(OSR)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .clear_i(cnt_clr),
    .mid_o(mid_hit), .full_o(full_hit)
  );

  assign detect   = (state_q == ST_IDLE) && tick16_i && !rx_s;
  assign last_idx = IDX_W'(cfg_dbits_i) + IDX_W'(MIN_BITS - 1);
  assign cnt_clr  = detect || ((state_q == ST_START) ? mid_hit : full_hit);

  always_comb begin
    tags_d.ferr = !rx_s;
    tags_d.brk  = !seen_one_q && !rx_s;
    tags_d.perr = cfg_par_en_i && ((^sr_q) ^ par_q ^ cfg_par_odd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sr_q       <= '0;
      par_q      <= 1'b0;
      seen_one_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (detect) state_q <= ST_START;
        ST_START: if (mid_hit) begin
          if (rx_s) state_q <= ST_IDLE;  // false start
          else begin
            state_q    <= ST_DATA;
            idx_q      <= '0;
            sr_q       <= '0;
            par_q      <= 1'b0;
            seen_one_q <= 1'b0;
          end
        end
        ST_DATA: if (full_hit) begin
          sr_q[idx_q] <= rx_s;
          seen_one_q  <= seen_one_q | rx_s;
          if (idx_q == last_idx) state_q <= cfg_par_en_i ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_PAR: if (full_hit) begin
          par_q      <= rx_s;
          seen_one_q <= seen_one_q | rx_s;
          state_q    <= ST_STOP;
        end
        ST_STOP: if (full_hit) state_q <= tags_d.brk ? ST_BRKWAIT : ST_IDLE;
        ST_BRKWAIT: if (tick16_i && rx_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Output stage: one-cycle write strobe, sticky overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      tags_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (ovr_clr_i) ovr_q <= 1'b0;
      if ((state_q == ST_STOP) && full_hit) begin
        if (fifo_full_i) ovr_q <= 1'b1;
        else begin
          wr_q   <= 1'b1;
          data_q <= sr_q;
          tags_q <= tags_d;
        end
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_data_o = data_q;
  assign wr_brk_o  = tags_q.brk;
  assign wr_ferr_o = tags_q.ferr;
  assign wr_perr_o = tags_q.perr;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_full_i,
  input logic              ovr_clr_i,
  input logic [1:0]        cfg_dbits_i,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_brk_o,
  input logic              wr_ferr_o,
  input logic              ovr_o
);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  a_r8_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !$past(fifo_full_i));

  a_r8_ovr_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(fifo_full_i));

  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(ovr_clr_i));

  a_r6_break_is_zero_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_brk_o) |-> (wr_data_o == '0 && wr_ferr_o));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && cfg_dbits_i == 2'd0) |-> (wr_data_o[DATA_W-1:DATA_W-3] == '0));
endmodule

bind serial_rx_frontend srx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serial_rx_frontend_bench.sv
module serial_rx_frontend_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rxd = 1'b1;
  logic [1:0] dbits = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, full = 1'b0, oclr = 1'b0;
  logic       wr_en, brk, ferr, perr, ovr;
  logic [7:0] wdata;

  int total = 0, bad = 0, n_wr = 0;
  logic [7:0] cap_data;
  logic cap_brk, cap_ferr, cap_perr;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_rx_frontend u_serial_rx_frontend (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .cfg_dbits_i(dbits), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
    .fifo_full_i(full), .ovr_clr_i(oclr),
    .wr_en_o(wr_en), .wr_data_o(wdata), .wr_brk_o(brk),
    .wr_ferr_o(ferr), .wr_perr_o(perr), .ovr_o(ovr)
  );

  always @(negedge clk) if (wr_en) begin
    n_wr++;
    cap_data = wdata; cap_brk = brk; cap_ferr = ferr; cap_perr = perr;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one tick slot: line level held, tick on the 3rd clock
  task automatic slots(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = lvl;
      @(negedge clk); @(negedge clk);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic flip_par,
                      input logic stop);
    logic p;
    p = (^(d & 8'((1 << nb) - 1))) ^ par_odd ^ flip_par;
    slots(1'b0, 16);
    for (int b = 0; b < nb; b++) slots(d[b], 16);
    if (par_en) slots(p, 16);
    slots(stop, 16);
    slots(1'b1, 32);
  endtask

  task automatic frame_chk(input logic [7:0] d, input logic flip_par,
                           input logic stop, input string tag);
    int nb;
    logic [7:0] m;
    logic p;
    nb = int'(dbits) + 5;
    m = d & 8'((1 << nb) - 1);
    p = (^m) ^ par_odd ^ flip_par;
    n_wr = 0;
    send(d, nb, flip_par, stop);
    chk({tag, " R7 write count"}, n_wr, 1);
    chk({tag, " R3 data"}, cap_data, m);
    chk({tag, " R5 ferr"}, cap_ferr, !stop);
    chk({tag, " R4 perr"}, cap_perr, par_en && flip_par);
    chk({tag, " R6 brk"}, cap_brk, (m == 0) && !stop && (!par_en || !p));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and idle line
    chk("R1 wr_en after reset", wr_en, 0);
    chk("R1 ovr after reset", ovr, 0);
    n_wr = 0; slots(1'b1, 40);
    chk("R1 no write on idle", n_wr, 0);

    // R3/R4/R5/R7 sweep: widths x parity modes
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        dbits = 2'(w); par_en = (pm != 0); par_odd = (pm == 2);
        foreach (vals[v]) frame_chk(vals[v], 1'b0, 1'b1, "sweep");
        if (par_en) frame_chk(8'h3C, 1'b1, 1'b1, "badpar R4");
        frame_chk(8'h01, 1'b0, 1'b0, "badstop R5");
      end
    end

    // R2: low pulse of exactly 8 slots is rejected
    dbits = 2'd3; par_en = 1'b0; par_odd = 1'b0;
    n_wr = 0; slots(1'b0, 8); slots(1'b1, 200);
    chk("R2 short start rejected", n_wr, 0);
    n_wr = 0; slots(1'b0, 3); slots(1'b1, 200);
    chk("R2 glitch rejected", n_wr, 0);
    frame_chk(8'hC3, 1'b0, 1'b1, "R2 after glitch");

    // R6: long break, one write, hold-off until high
    n_wr = 0; slots(1'b0, 16 * 40);
    chk("R6 break single write", n_wr, 1);
    chk("R6 brk tag", cap_brk, 1);
    chk("R6 break data", cap_data, 0);
    chk("R6 break ferr", cap_ferr, 1);
    slots(1'b1, 32);
    chk("R6 no write on release", n_wr, 1);
    frame_chk(8'h96, 1'b0, 1'b1, "R6 rearm");

    // R8: overrun
    full = 1'b1; n_wr = 0;
    send(8'h77, 8, 1'b0, 1'b1);
    chk("R8 dropped on full", n_wr, 0);
    chk("R8 ovr set", ovr, 1);
    full = 1'b0;
    frame_chk(8'h11, 1'b0, 1'b1, "R8 after overrun");
    chk("R8 ovr sticky", ovr, 1);
    oclr = 1'b1; @(negedge clk); oclr = 1'b0; @(negedge clk);
    chk("R8 ovr cleared", ovr, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule